// File: doc/BRIEF.md
# Cycle-Synchronous Control Pulse Generator

This block turns one external cycle-sync line into two timing strobes that stay locked to a periodic communication cycle. The cycle can last from 62.5 µs to 65 ms. A prescaler divides the master clock down to a one-clock tick every microsecond. A microsecond counter restarts at each active sync edge. Both outputs are scheduled against that count.

The control output gives one pulse per cycle, with a programmable delay, width and polarity. The divided output gives a burst of 1 µs pulses, with a programmable start time, pulse count, spacing and polarity. A skip setting lets the burst appear in only one cycle out of several. Each new sync edge drops whatever is still pending and starts the schedule again from zero.

Software programs the block through a plain write port of eight 16-bit registers. All outputs are registered on the rising edge of the master clock.

Top module: `cycle_strobe_gen`

## Requirements
- R1: After reset, `conOut` and `divOut` are 0, and all three polarity bits default to 1 (active-high). The prescaler divider defaults to 63, and every timing field defaults to 0. Neither output pulses before the first active sync edge.
- R2: A write with `cfgWe`=1 loads `cfgData` into the register at `cfgAddr` on the next clock edge. The registers are: 0 = polarity bits (bit0 sync, bit1 control, bit2 divided); 1 = prescaler divider; 2 = control delay in µs; 3 = control width in µs; 4 = divided start in µs; 5 = divided pulse count; 6 = divided spacing in µs; 7 = cycle skip.
- R3: `syncIn` passes through a two-flop synchronizer. Only the edge selected by the sync polarity bit (1 = rising, 0 = falling) starts a cycle. The opposite edge has no effect.
- R4: One microsecond lasts (divider + 1) clocks. If `syncIn` changes just after clock edge n, an output event scheduled at microsecond u changes the pin at clock edge n + 4 + (divider + 1)·u.
- R5: The control output is active from microsecond `delay` up to, but not including, microsecond `delay + width`, once per cycle. A width of 0 gives no pulse.
- R6: The divided output produces `count` pulses. Pulse i starts at microsecond `start + i·spacing` and lasts exactly 1 µs. A spacing of 0 behaves as a spacing of 1, so the pulses merge into one run of `count` µs.
- R7: A divided pulse count of 0 keeps the divided output inactive for the whole cycle.
- R8: With skip value K, the burst fires in one cycle and then stays silent for the next K cycles. The first cycle after reset fires. K = 0 fires every cycle.
- R9: An active sync edge that arrives while pulses are pending ends any active control pulse. It cancels the remaining divided pulses and restarts both schedules from microsecond 0.
- R10: Each output shows the inverse of its polarity bit when inactive. A write to the polarity register changes the idle level of the pins two clocks after the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register select |
| cfgData | input | 16 | Register write data |
| syncIn | input | 1 | External cycle-sync line |
| conOut | output | 1 | Once-per-cycle control pulse |
| divOut | output | 1 | Divided 1 µs pulse train |

## Verification
The bench builds the block with its default widths: a 16-bit microsecond counter, an 8-bit pulse count and an 8-bit skip counter. It then programs small divider values, 3 and later 1, so that one microsecond lasts only four or two clocks. This keeps every scheduled edge, the cancellation window and a full six-cycle skip pattern within a few thousand clocks. Each expected edge is therefore placed at an exact clock index that the bench works out on its own.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int TIME_W = 16;
  localparam int PRE_W  = 7;
  localparam int CNT_W  = 8;
  localparam int SKIP_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_POL   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_PRE   = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CDLY  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CWID  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_DSTRT = 3'd4;
  localparam logic [ADDR_W-1:0] REG_DCNT  = 3'd5;
  localparam logic [ADDR_W-1:0] REG_DSTEP = 3'd6;
  localparam logic [ADDR_W-1:0] REG_DSKIP = 3'd7;

  // strobes from the time base to the pulse datapath
  typedef struct packed {
    logic syncHit;
    logic usTick;
    logic live;
  } csgStrobe_t;

  typedef struct packed {
    logic             syncPol;
    logic [PRE_W-1:0] preDiv;
  } csgTimeCfg_t;

  typedef struct packed {
    logic              conPol;
    logic              divPol;
    logic [TIME_W-1:0] conDelay;
    logic [TIME_W-1:0] conWidth;
    logic [TIME_W-1:0] divStart;
    logic [TIME_W-1:0] divStep;
    logic [CNT_W-1:0]  divCount;
    logic [SKIP_W-1:0] divSkip;
  } csgPulseCfg_t;
endpackage

// File: rtl/csg_regs.sv
module csg_regs
  import csg_pkg::*;
#(
  parameter logic [PRE_W-1:0] PRE_RESET = 7'd63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TIME_W-1:0] data,
  output csgTimeCfg_t       timeCfg,
  output csgPulseCfg_t      pulseCfg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeCfg.syncPol   <= 1'b1;
      timeCfg.preDiv    <= PRE_RESET;
      pulseCfg.conPol   <= 1'b1;
      pulseCfg.divPol   <= 1'b1;
      pulseCfg.conDelay <= '0;
      pulseCfg.conWidth <= '0;
      pulseCfg.divStart <= '0;
      pulseCfg.divStep  <= '0;
      pulseCfg.divCount <= '0;
      pulseCfg.divSkip  <= '0;
    end else if (we) begin
      case (addr)
        REG_POL: begin
          timeCfg.syncPol <= data[0];
          pulseCfg.conPol <= data[1];
          pulseCfg.divPol <= data[2];
        end
        REG_PRE:   timeCfg.preDiv     <= data[PRE_W-1:0];
        REG_CDLY:  pulseCfg.conDelay  <= data;
        REG_CWID:  pulseCfg.conWidth  <= data;
        REG_DSTRT: pulseCfg.divStart  <= data;
        REG_DCNT:  pulseCfg.divCount  <= data[CNT_W-1:0];
        REG_DSTEP: pulseCfg.divStep   <= data;
        default:   pulseCfg.divSkip   <= data[SKIP_W-1:0];
      endcase
    end
  end

  assert_pol_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (we && addr == REG_POL) |=>
      ({pulseCfg.divPol, pulseCfg.conPol, timeCfg.syncPol} == $past(data[2:0])));
endmodule

// File: rtl/csg_ctrl.sv
module csg_ctrl
  import csg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  csgTimeCfg_t       cfg,
  output csgStrobe_t        strobe,
  output logic [TIME_W-1:0] usNow
);
  logic [1:0]       syncPipe;
  logic             syncPrev;
  logic [PRE_W-1:0] preCnt;
  logic             live;
  logic             syncHit;
  logic             tickRaw;

  always_comb begin
    syncHit = cfg.syncPol ? (syncPipe[1] & ~syncPrev) : (~syncPipe[1] & syncPrev);
    tickRaw = (preCnt >= cfg.preDiv);
    strobe.syncHit = syncHit;
    strobe.usTick  = tickRaw & ~syncHit;
    strobe.live    = live;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      syncPrev <= 1'b0;
      preCnt   <= '0;
      usNow    <= '0;
      live     <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[0], syncIn};
      syncPrev <= syncPipe[1];
      if (syncHit) begin
        preCnt <= '0;
        usNow  <= '0;
        live   <= 1'b1;
      end else if (tickRaw) begin
        preCnt <= '0;
        if (usNow != '1) usNow <= usNow + TIME_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assert_us_origin_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.syncHit |=> (usNow == '0 && strobe.live));

  assert_us_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.syncHit && !strobe.usTick) |=> $stable(usNow));

  assert_us_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (usNow != $past(usNow)) |-> (usNow == '0 || usNow == $past(usNow) + TIME_W'(1)));
endmodule

// File: rtl/csg_datapath.sv
module csg_datapath
  import csg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csgStrobe_t        strobe,
  input  logic [TIME_W-1:0] usNow,
  input  csgPulseCfg_t      cfg,
  output logic              conOut,
  output logic              divOut
);
  logic [TIME_W-1:0] nextAt;
  logic [CNT_W-1:0]  left;
  logic [SKIP_W-1:0] skipCnt;
  logic [TIME_W-1:0] sinceDelay;
  logic [TIME_W-1:0] stepEff;
  logic [TIME_W:0]   nextSum;
  logic              conActive;
  logic              divHit;
  logic              fireNow;

  always_comb begin
    sinceDelay = usNow - cfg.conDelay;
    conActive  = strobe.live && (usNow >= cfg.conDelay) && (sinceDelay < cfg.conWidth);
    divHit     = strobe.live && (left != '0) && (usNow == nextAt);
    stepEff    = (cfg.divStep == '0) ? TIME_W'(1) : cfg.divStep;
    nextSum    = {1'b0, nextAt} + {1'b0, stepEff};
    fireNow    = (skipCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextAt  <= '0;
      left    <= '0;
      skipCnt <= '0;
      conOut  <= 1'b0;
      divOut  <= 1'b0;
    end else begin
      if (strobe.syncHit) begin
        nextAt  <= cfg.divStart;
        left    <= fireNow ? cfg.divCount : '0;
        skipCnt <= fireNow ? cfg.divSkip : skipCnt - SKIP_W'(1);
      end else if (strobe.usTick && divHit) begin
        nextAt <= nextSum[TIME_W-1:0];
        left   <= nextSum[TIME_W] ? '0 : left - CNT_W'(1);
      end
      conOut <= conActive ? cfg.conPol : ~cfg.conPol;
      divOut <= divHit ? cfg.divPol : ~cfg.divPol;
    end
  end

  assert_div_count_down_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.syncHit |=> (left <= $past(left)));

  assert_skip_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.syncHit && skipCnt != '0) |=> (left == '0));

  assert_idle_before_sync_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.live |=> (conOut == ~$past(cfg.conPol) && divOut == ~$past(cfg.divPol)));
endmodule

// File: rtl/cycle_strobe_gen.sv
module cycle_strobe_gen
  import csg_pkg::*;
#(
  parameter logic [PRE_W-1:0] PRE_RESET = 7'd63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [TIME_W-1:0] cfgData,
  input  logic              syncIn,
  output logic              conOut,
  output logic              divOut
);
  csgTimeCfg_t       timeCfg;
  csgPulseCfg_t      pulseCfg;
  csgStrobe_t        strobe;
  logic [TIME_W-1:0] usNow;

  csg_regs #(.PRE_RESET(PRE_RESET)) uRegs (
    .clk(clk), .rstN(rstN), .we(cfgWe), .addr(cfgAddr), .data(cfgData),
    .timeCfg(timeCfg), .pulseCfg(pulseCfg)
  );

  csg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .cfg(timeCfg),
    .strobe(strobe), .usNow(usNow)
  );

  csg_datapath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .usNow(usNow), .cfg(pulseCfg),
    .conOut(conOut), .divOut(divOut)
  );
endmodule

// File: tb/cycle_strobe_gen_test.sv
module cycle_strobe_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        syncIn = 1'b0;
  logic        conOut, divOut;

  longint cyc = 0;
  int     total = 0, bad = 0;
  longint conQ[$];
  longint divQ[$];
  string  curReq = "R1";
  bit     monOn = 0;
  logic   prevCon = 1'b0, prevDiv = 1'b0;
  int     bD = 64, bDelay = 0, bWidth = 0, bStart = 0, bCount = 0, bStep = 0;
  bit     bConPol = 1, bDivPol = 1;

  cycle_strobe_gen uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .syncIn(syncIn), .conOut(conOut), .divOut(divOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic note(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected item encoding: cycle*2 + level
  task automatic push(int ch, bit lvl, longint at);
    if (ch == 0) conQ.push_back(at * 2 + lvl);
    else         divQ.push_back(at * 2 + lvl);
  endtask

  task automatic popCheck(int ch, logic lvl);
    longint item;
    bit     empty;
    item = 0;
    if (ch == 0) begin
      empty = (conQ.size() == 0);
      if (!empty) item = conQ.pop_front();
    end else begin
      empty = (divQ.size() == 0);
      if (!empty) item = divQ.pop_front();
    end
    if (empty)
      note(0, curReq, ch == 0 ? "unexpected conOut edge (cycle*2+level)"
                              : "unexpected divOut edge (cycle*2+level)", cyc * 2 + lvl, -1);
    else
      note(item == cyc * 2 + lvl, curReq,
           ch == 0 ? "conOut edge (cycle*2+level)" : "divOut edge (cycle*2+level)",
           cyc * 2 + lvl, item);
  endtask

  // monitor: compares every observed output edge with the scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (conOut !== prevCon) begin
        popCheck(0, conOut);
        prevCon = conOut;
      end
      if (divOut !== prevDiv) begin
        popCheck(1, divOut);
        prevDiv = divOut;
      end
    end
  end

  task automatic waitUntil(longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic writeReg(logic [2:0] a, logic [15:0] d, output longint w);
    @(negedge clk);
    w = cyc;
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // driver: pushes the edges one cycle starting at sync cycle s should produce
  task automatic expectCycle(longint s, bit fire);
    int st;
    if (bWidth > 0) begin
      push(0, bConPol,  s + 4 + bD * bDelay);
      push(0, !bConPol, s + 4 + bD * (bDelay + bWidth));
    end
    if (fire && bCount > 0) begin
      st = (bStep == 0) ? 1 : bStep;
      if (st == 1) begin
        push(1, bDivPol,  s + 4 + bD * bStart);
        push(1, !bDivPol, s + 4 + bD * (bStart + bCount));
      end else begin
        for (int i = 0; i < bCount; i++) begin
          push(1, bDivPol,  s + 4 + bD * (bStart + i * st));
          push(1, !bDivPol, s + 4 + bD * (bStart + i * st + 1));
        end
      end
    end
  endtask

  task automatic drainCheck();
    note(conQ.size() == 0, curReq, "conOut edges still missing", conQ.size(), 0);
    note(divQ.size() == 0, curReq, "divOut edges still missing", divQ.size(), 0);
  endtask

  // syncHigh: the rising edge is the active one, else the falling edge
  task automatic runCycle(bit syncHigh, bit fire);
    longint s0, s;
    @(negedge clk);
    s0 = cyc;
    syncIn = 1'b1;
    if (syncHigh) begin
      s = s0;
      expectCycle(s, fire);
    end
    waitUntil(s0 + 10);
    syncIn = 1'b0;
    if (!syncHigh) begin
      s = cyc;
      expectCycle(s, fire);
    end
    waitUntil(s0 + 240);
    drainCheck();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    longint w, s;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    monOn = 1;

    // R1: idle outputs after reset, nothing before a sync
    curReq = "R1";
    repeat (40) @(negedge clk);
    note(conOut === 1'b0, "R1", "conOut after reset", conOut, 0);
    note(divOut === 1'b0, "R1", "divOut after reset", divOut, 0);

    // R2: program the schedule
    curReq = "R2";
    writeReg(3'd1, 16'd3, w); bD = 4;
    writeReg(3'd2, 16'd5, w); bDelay = 5;
    writeReg(3'd3, 16'd3, w); bWidth = 3;
    writeReg(3'd4, 16'd2, w); bStart = 2;
    writeReg(3'd5, 16'd3, w); bCount = 3;
    writeReg(3'd6, 16'd4, w); bStep = 4;
    writeReg(3'd7, 16'd0, w);
    repeat (20) @(negedge clk);
    drainCheck();

    // R3/R4/R5: trailing sync edge ignored, exact edge timing, control pulse
    curReq = "R3";
    runCycle(1, 1);
    curReq = "R4";
    runCycle(1, 1);
    curReq = "R5";
    runCycle(1, 1);

    // R9: a second sync lands while the control pulse is high
    curReq = "R9";
    @(negedge clk);
    s = cyc;
    syncIn = 1'b1;
    push(0, 1, s + 24);
    push(0, 0, s + 34);
    push(1, 1, s + 12);
    push(1, 0, s + 16);
    push(1, 1, s + 28);
    push(1, 0, s + 32);
    waitUntil(s + 10);
    syncIn = 1'b0;
    waitUntil(s + 30);
    syncIn = 1'b1;
    expectCycle(s + 30, 1);
    waitUntil(s + 40);
    syncIn = 1'b0;
    waitUntil(s + 30 + 240);
    drainCheck();

    // R7: count 0 silences the divided output
    curReq = "R7";
    writeReg(3'd5, 16'd0, w); bCount = 0;
    runCycle(1, 1);

    // R8: skip 2 -> fire, skip, skip, fire, skip, skip
    curReq = "R8";
    writeReg(3'd5, 16'd2, w); bCount = 2;
    writeReg(3'd7, 16'd2, w);
    runCycle(1, 1);
    runCycle(1, 0);
    runCycle(1, 0);
    runCycle(1, 1);
    runCycle(1, 0);
    runCycle(1, 0);

    // R6: spacing 0 merges pulses, with a faster microsecond
    curReq = "R6";
    writeReg(3'd7, 16'd0, w);
    writeReg(3'd6, 16'd0, w); bStep = 0;
    writeReg(3'd1, 16'd1, w); bD = 2;
    runCycle(1, 1);

    // R10: inverted outputs and falling-edge sync
    curReq = "R10";
    writeReg(3'd0, 16'd0, w);
    bConPol = 0;
    bDivPol = 0;
    push(0, 1, w + 2);
    push(1, 1, w + 2);
    runCycle(0, 1);

    summary();
    $finish;
  end
endmodule